// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel Sequencer

This block sequences a single DMA channel through a linked list of transfer descriptors. Software programs the channel through a small register write port. The control word holds two command bits, the interrupt enables, a burst-lock flag and a 16-bit byte count. The two command bits choose one of four actions:

- freeze the channel;
- move one buffer and then stop;
- skip the loaded buffer and fetch the following descriptor;
- move the buffer and then fetch the following descriptor on its own.

Descriptors are read through a one-outstanding request/response memory port. Data movement is delegated to an external mover through a request/acknowledge handshake that reports the bytes taken on each beat and marks the last beat of a burst. When a running channel is told to stop, the sequencer first asks the external FIFO to empty. Only after that does it drop its enable flag, so software can tell when the channel is safe to reprogram: both the enable flag and the active flag read 0.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After a synchronous active-low reset, sts_en, sts_act, all three interrupt outputs, mem_req, mv_req and fifo_drain are 0, and remaining is 0.
- R2: The control word (reg_sel = 0) decodes as follows:
  - bit 0 enable, bit 1 link;
  - bit 2 end-of-transfer enable, bit 3 end-of-buffer enable;
  - bit 4 end-of-transfer interrupt enable, bit 5 end-of-buffer interrupt enable, bit 6 descriptor-loaded interrupt enable;
  - bit 7 burst lock;
  - bits 31:16 byte count.

  reg_sel = 1 writes the next-descriptor pointer and reg_sel = 2 writes the buffer address. Writes are accepted only while the channel is idle or running.
- R3: With enable = 0 and link = 0 the channel is frozen. A request starts no data movement and no descriptor fetch, and sts_en and sts_act stay 0.
- R4: With enable = 1 and link = 0 the channel raises mv_req while xfer_req is high and the byte count is nonzero. mv_addr starts at the buffer address and advances by the accepted bytes. When the buffer ends, sts_en and sts_act clear and no descriptor is fetched.
- R5: With enable = 0 and link = 1, a request starts a descriptor fetch without moving data. The fetch reads four words at pointer, +4, +8 and +12, in this order: next pointer, buffer address, control word, spare.
- R6: With enable = 1 and link = 1, once the buffer ends sts_en clears and the fetch of the next descriptor starts in the following cycle. The loaded control word's enable decides whether the channel runs again.
- R7: Loading a descriptor overwrites the pointer, buffer address, byte count and control fields. irq_desc pulses for one cycle when bit 6 of the loaded control word is set.
- R8: Each acknowledged beat lowers remaining by mv_bytes. Reaching 0 pulses irq_eob for one cycle when bit 5 is set. The buffer ends only when bit 3 is set; otherwise the channel stays enabled with mv_req low.
- R9: When ep_end is high while running and bit 2 is set, the buffer ends. irq_eot pulses one cycle later when bit 4 is also set.
- R10: Writing enable = 0 to a running channel raises fifo_drain. sts_en is held at 1 until fifo_empty is seen, and then sts_en and sts_act clear on the next edge.
- R11: With burst lock set, a stop written inside an open burst keeps mv_req high until the beat with mv_last. Draining begins only after that beat.
- R12: After a loaded descriptor leaves the channel disabled, a software write with enable = 1 starts the described transfer from the loaded buffer address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 next pointer, 2 buffer address |
| reg_wdata | input | 32 | Register write data |
| xfer_req | input | 1 | Endpoint transfer request pending |
| ep_end | input | 1 | Endpoint end-of-transfer event |
| mem_req | output | 1 | Descriptor read request, held until mem_rvalid |
| mem_addr | output | AW | Descriptor word address |
| mem_rvalid | input | 1 | Descriptor read data valid |
| mem_rdata | input | 32 | Descriptor read data |
| mv_req | output | 1 | Data mover request |
| mv_addr | output | AW | Current buffer address |
| mv_ack | input | 1 | Data mover beat accepted |
| mv_bytes | input | BW | Bytes accepted on this beat |
| mv_last | input | 1 | Last beat of the burst |
| fifo_drain | output | 1 | Empty the data FIFO |
| fifo_empty | input | 1 | Data FIFO is empty |
| sts_en | output | 1 | Channel enable status |
| sts_act | output | 1 | Channel active status |
| remaining | output | 16 | Bytes left in the buffer |
| irq_eot | output | 1 | End-of-transfer interrupt pulse |
| irq_eob | output | 1 | End-of-buffer interrupt pulse |
| irq_desc | output | 1 | Descriptor-loaded interrupt pulse |

## Verification
The final data beat, which empties the byte count, and the endpoint's end-of-transfer event can land in the same cycle. The bench provokes this by raising ep_end on the very beat that brings remaining to zero, with both end conditions and both interrupt enables set. It then expects irq_eot and irq_eob high together in the next cycle, a single buffer end with sts_en and sts_act cleared, and both pulses gone one cycle later. A second run raises ep_end alone mid-buffer to confirm that only irq_eot fires and that the byte count is left untouched.

// File: rtl/dma_chain_pkg.sv
// Shared definitions for the descriptor-chained DMA channel sequencer.
// Holds control-word bit positions, register select codes, the decoded
// control fields and the channel state encoding.
package dma_chain_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 16;

    localparam int CW_EN     = 0;
    localparam int CW_LINK   = 1;
    localparam int CW_EOT_EN = 2;
    localparam int CW_EOB_EN = 3;
    localparam int CW_EOT_IE = 4;
    localparam int CW_EOB_IE = 5;
    localparam int CW_DSC_IE = 6;
    localparam int CW_LOCK   = 7;
    localparam int CW_LEN_LO = 16;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_NEXT = 2'd1;
    localparam logic [1:0] SEL_BUF  = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_FETCH = 2'd3
    } chan_state_t;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             lock;
        logic             dsc_ie;
        logic             eob_ie;
        logic             eot_ie;
        logic             eob_en;
        logic             eot_en;
    } ctrl_t;

    // Split a raw control word into its named fields.
    function automatic ctrl_t unpack_ctrl(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.len    = w[CW_LEN_LO +: LEN_W];
        c.lock   = w[CW_LOCK];
        c.dsc_ie = w[CW_DSC_IE];
        c.eob_ie = w[CW_EOB_IE];
        c.eot_ie = w[CW_EOT_IE];
        c.eob_en = w[CW_EOB_EN];
        c.eot_en = w[CW_EOT_EN];
        return c;
    endfunction

endpackage

// File: rtl/dma_desc_fetch.sv
// Descriptor fetch engine. On a start pulse it reads NWORDS consecutive
// 32-bit words from base, one request at a time. mem_req and mem_addr are
// held until mem_rvalid. The first three words are kept for the sequencer,
// and done pulses with the last response.
// Assumes: base is stable for the whole fetch; start is only raised while idle.
module dma_desc_fetch import dma_chain_pkg::*; #(
    parameter int AW     = 32,
    parameter int NWORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     base,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              done,
    output logic [WORD_W-1:0] w_next,
    output logic [WORD_W-1:0] w_buf,
    output logic [WORD_W-1:0] w_ctrl
);

    localparam int IDX_W = $clog2(NWORDS);
    localparam int KEEP  = 3;

    logic             busy_q;
    logic [IDX_W-1:0] idx_q;
    logic [WORD_W-1:0] keep_q [KEEP];

    assign mem_req  = busy_q;
    assign mem_addr = base + (AW'(idx_q) << 2);
    assign done     = busy_q && mem_rvalid && (idx_q == IDX_W'(NWORDS - 1));
    assign w_next   = keep_q[0];
    assign w_buf    = keep_q[1];
    assign w_ctrl   = keep_q[2];

    // Word sequencing: walk the index while the engine is busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
        end else if (busy_q && mem_rvalid) begin
            if (idx_q == IDX_W'(NWORDS - 1)) busy_q <= 1'b0;
            else                             idx_q  <= idx_q + 1'b1;
        end
    end

    // One capture register per kept word.
    for (genvar k = 0; k < KEEP; k++) begin : g_keep
        always_ff @(posedge clk) begin
            if (!rst_n)                                          keep_q[k] <= '0;
            else if (busy_q && mem_rvalid && idx_q == IDX_W'(k)) keep_q[k] <= mem_rdata;
        end
    end

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

endmodule

// File: rtl/dma_xfer_track.sv
// Buffer progress tracker. Keeps the remaining byte count, the current
// buffer address and whether a data-mover burst is open. hit_zero flags
// the beat that uses up the byte count.
// Assumes: acks arrive only while the mover is requested; BW <= LW.
module dma_xfer_track #(
    parameter int AW = 32,
    parameter int LW = 16,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_len,
    input  logic [LW-1:0] len_in,
    input  logic          load_addr,
    input  logic [AW-1:0] addr_in,
    input  logic          ack,
    input  logic [BW-1:0] bytes,
    input  logic          last,
    output logic [LW-1:0] len_q,
    output logic [AW-1:0] addr_q,
    output logic          burst_open,
    output logic          hit_zero
);

    logic [LW-1:0] step;

    assign step     = LW'(bytes);
    assign hit_zero = ack && (len_q != '0) && (step >= len_q);

    // Byte count: a load wins over a beat; the last beat clamps to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)        len_q <= '0;
        else if (load_len) len_q <= len_in;
        else if (ack)      len_q <= hit_zero ? '0 : len_q - step;
    end

    // Buffer address: advances by the bytes of each accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n)         addr_q <= '0;
        else if (load_addr) addr_q <= addr_in;
        else if (ack)       addr_q <= addr_q + AW'(bytes);
    end

    // Burst tracking: open after a non-final beat, closed by the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)   burst_open <= 1'b0;
        else if (ack) burst_open <= !last;
    end

    // R8
    len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !load_len && !hit_zero) |=> (len_q == $past(len_q) - LW'($past(bytes))));

    // R8
    len_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !load_len && hit_zero) |=> (len_q == '0));

endmodule

// File: rtl/dma_chain_ctrl.sv
// Descriptor-chained DMA channel sequencer (top). Decodes the two command
// bits of the control word into freeze / run-and-stop / skip / run-and-link.
// It drives the data mover and the descriptor fetch engine, runs the
// drain-then-clear stop sequence, and pulses the three interrupts.
// Assumes: mv_ack only while mv_req is high; the memory answers every request.
module dma_chain_ctrl import dma_chain_pkg::*; #(
    parameter int AW         = 32,
    parameter int BW         = 4,
    parameter int DESC_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              xfer_req,
    input  logic              ep_end,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mv_req,
    output logic [AW-1:0]     mv_addr,
    input  logic              mv_ack,
    input  logic [BW-1:0]     mv_bytes,
    input  logic              mv_last,
    output logic              fifo_drain,
    input  logic              fifo_empty,
    output logic              sts_en,
    output logic              sts_act,
    output logic [LEN_W-1:0]  remaining,
    output logic              irq_eot,
    output logic              irq_eob,
    output logic              irq_desc
);

    chan_state_t       state_q;
    logic              en_q, ln_q, stop_pend_q;
    ctrl_t             ctl_q;
    logic [AW-1:0]     ptr_q;
    logic              irq_eot_q, irq_eob_q, irq_desc_q;

    logic              acc_ok, wr_ctrl, wr_next, wr_buf, stop_wr;
    ctrl_t             wctl, dctl;
    logic              fetch_start, fetch_done;
    logic [WORD_W-1:0] d_next, d_buf, d_ctrl;
    logic              hit_zero, burst_open, open_after, need_hold, end_ev;
    logic [LEN_W-1:0]  len_cur;

    // Register-port decode: writes only while idle or running.
    always_comb begin
        acc_ok  = (state_q == ST_IDLE) || (state_q == ST_RUN);
        wr_ctrl = reg_wr && acc_ok && (reg_sel == SEL_CTRL);
        wr_next = reg_wr && acc_ok && (reg_sel == SEL_NEXT);
        wr_buf  = reg_wr && acc_ok && (reg_sel == SEL_BUF);
        wctl    = unpack_ctrl(reg_wdata);
        dctl    = unpack_ctrl(d_ctrl);
        stop_wr = wr_ctrl && (state_q == ST_RUN) && !reg_wdata[CW_EN];
    end

    // Transfer events: buffer end, burst-lock hold and fetch launch.
    always_comb begin
        end_ev      = (state_q == ST_RUN) &&
                      ((hit_zero && ctl_q.eob_en) || (ep_end && ctl_q.eot_en));
        open_after  = burst_open ? !(mv_ack && mv_last) : (mv_ack && !mv_last);
        need_hold   = ctl_q.lock && open_after;
        fetch_start = ((state_q == ST_IDLE) && !wr_ctrl && ln_q && xfer_req) ||
                      ((state_q == ST_RUN) && !stop_wr && !stop_pend_q && end_ev && ln_q);
    end

    dma_desc_fetch #(.AW(AW), .NWORDS(DESC_WORDS)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (fetch_start),
        .base       (ptr_q),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .done       (fetch_done),
        .w_next     (d_next),
        .w_buf      (d_buf),
        .w_ctrl     (d_ctrl)
    );

    dma_xfer_track #(.AW(AW), .LW(LEN_W), .BW(BW)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_len   ((wr_ctrl && !stop_wr) || fetch_done),
        .len_in     (fetch_done ? dctl.len : wctl.len),
        .load_addr  (wr_buf || fetch_done),
        .addr_in    (fetch_done ? AW'(d_buf) : AW'(reg_wdata)),
        .ack        (mv_ack),
        .bytes      (mv_bytes),
        .last       (mv_last),
        .len_q      (len_cur),
        .addr_q     (mv_addr),
        .burst_open (burst_open),
        .hit_zero   (hit_zero)
    );

    // Channel sequencer: command decode, stop/drain, end handling, descriptor load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            en_q        <= 1'b0;
            ln_q        <= 1'b0;
            stop_pend_q <= 1'b0;
            ctl_q       <= '0;
            ptr_q       <= '0;
            irq_eot_q   <= 1'b0;
            irq_eob_q   <= 1'b0;
            irq_desc_q  <= 1'b0;
        end else begin
            irq_eob_q  <= hit_zero && ctl_q.eob_ie;
            irq_eot_q  <= (state_q == ST_RUN) && ep_end && ctl_q.eot_en && ctl_q.eot_ie;
            irq_desc_q <= fetch_done && dctl.dsc_ie;
            if (wr_next) ptr_q <= AW'(reg_wdata);
            case (state_q)
                ST_IDLE: begin
                    if (wr_ctrl) begin
                        ctl_q   <= wctl;
                        en_q    <= reg_wdata[CW_EN];
                        ln_q    <= reg_wdata[CW_LINK];
                        state_q <= reg_wdata[CW_EN] ? ST_RUN : ST_IDLE;
                    end else if (fetch_start) begin
                        state_q <= ST_FETCH;
                    end
                end
                ST_RUN: begin
                    if (stop_wr) begin
                        ln_q <= reg_wdata[CW_LINK];
                        if (need_hold) stop_pend_q <= 1'b1;
                        else           state_q     <= ST_DRAIN;
                    end else begin
                        if (wr_ctrl) begin
                            ctl_q <= wctl;
                            ln_q  <= reg_wdata[CW_LINK];
                        end
                        if (stop_pend_q) begin
                            if (mv_ack && mv_last) begin
                                stop_pend_q <= 1'b0;
                                state_q     <= ST_DRAIN;
                            end
                        end else if (end_ev) begin
                            en_q    <= 1'b0;
                            state_q <= fetch_start ? ST_FETCH : ST_IDLE;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (fifo_empty) begin
                        en_q    <= 1'b0;
                        state_q <= ST_IDLE;
                    end
                end
                ST_FETCH: begin
                    if (fetch_done) begin
                        ptr_q   <= AW'(d_next);
                        ctl_q   <= dctl;
                        en_q    <= d_ctrl[CW_EN];
                        ln_q    <= d_ctrl[CW_LINK];
                        state_q <= d_ctrl[CW_EN] ? ST_RUN : ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output drive: mover request is gated by a pending stop unless a burst is open.
    always_comb begin
        mv_req     = (state_q == ST_RUN) && (len_cur != '0) &&
                     (stop_pend_q ? burst_open : (xfer_req || burst_open));
        fifo_drain = (state_q == ST_DRAIN);
        sts_en     = en_q;
        sts_act    = (state_q != ST_IDLE);
        remaining  = len_cur;
        irq_eot    = irq_eot_q;
        irq_eob    = irq_eob_q;
        irq_desc   = irq_desc_q;
    end

    // R3
    frozen_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_en |-> !mv_req);

    // R10
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_drain && !fifo_empty) |=> sts_en);

    // R8
    eob_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_eob |=> !irq_eob);

    // R7
    desc_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_desc |-> $past(state_q == ST_FETCH));

    // R11
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && stop_pend_q && !(mv_ack && mv_last)) |=> !fifo_drain);

endmodule

// File: tb/sim_dma_chain_ctrl.sv
// Self-checking bench: a command-decode vector table walked by one loop,
// then directed tests for reset, chaining, stop/drain, burst lock and overlaps.
module sim_dma_chain_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [1:0]  reg_sel;
    logic [31:0] reg_wdata;
    logic        xfer_req, ep_end;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        mv_req;
    logic [31:0] mv_addr;
    logic        mv_ack;
    logic [3:0]  mv_bytes;
    logic        mv_last;
    logic        fifo_drain, fifo_empty;
    logic        sts_en, sts_act;
    logic [15:0] remaining;
    logic        irq_eot, irq_eob, irq_desc;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    dma_chain_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .xfer_req(xfer_req), .ep_end(ep_end),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mv_req(mv_req), .mv_addr(mv_addr),
        .mv_ack(mv_ack), .mv_bytes(mv_bytes), .mv_last(mv_last),
        .fifo_drain(fifo_drain), .fifo_empty(fifo_empty), .sts_en(sts_en),
        .sts_act(sts_act), .remaining(remaining), .irq_eot(irq_eot),
        .irq_eob(irq_eob), .irq_desc(irq_desc)
    );

    // {enable, link, request, exp sts_en, exp sts_act, exp mem_req, exp mv_req}
    localparam logic [6:0] VEC [6] = '{
        7'b0010000,   // R3 freeze
        7'b1011101,   // R4 run and stop
        7'b0110110,   // R5 skip
        7'b1111101,   // R6 run and link
        7'b1001100,   // R4 no request
        7'b0100000    // R5 no request
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = '0;
        xfer_req = 1'b0; ep_end = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
        mv_ack = 1'b0; mv_bytes = '0; mv_last = 1'b0; fifo_empty = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; #1;
    endtask

    task automatic beat(input logic [3:0] n, input logic lst);
        mv_ack = 1'b1; mv_bytes = n; mv_last = lst;
        @(negedge clk);
        mv_ack = 1'b0; mv_last = 1'b0; ep_end = 1'b0; #1;
    endtask

    task automatic serve(input logic [31:0] d);
        mem_rvalid = 1'b1; mem_rdata = d;
        @(negedge clk);
        mem_rvalid = 1'b0; #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] dw [4];

        // R1 reset state
        do_reset();
        #1;
        chk("R1 sts_en", 32'(sts_en), 0);
        chk("R1 sts_act", 32'(sts_act), 0);
        chk("R1 irqs", {29'b0, irq_eot, irq_eob, irq_desc}, 0);
        chk("R1 mem/mv/drain", {29'b0, mem_req, mv_req, fifo_drain}, 0);
        chk("R1 remaining", 32'(remaining), 0);

        // R2 command decode table (R3 R4 R5 R6)
        for (int i = 0; i < 6; i++) begin
            logic [6:0] v;
            v = VEC[i];
            do_reset();
            wr(2'd2, 32'h1000);
            wr(2'd0, 32'h0010_0008 | {30'b0, v[5], v[6]});
            xfer_req = v[4];
            tick(); tick();
            chk("R2 vec sts_en", 32'(sts_en), 32'(v[3]));
            chk("R2 vec sts_act", 32'(sts_act), 32'(v[2]));
            chk("R2 vec mem_req", 32'(mem_req), 32'(v[1]));
            chk("R2 vec mv_req", 32'(mv_req), 32'(v[0]));
        end

        // R4 R8 run and stop over two beats
        do_reset();
        wr(2'd2, 32'h1000);
        wr(2'd0, 32'h0008_0029);
        xfer_req = 1'b1; #1;
        chk("R4 mv_req", 32'(mv_req), 1);
        chk("R4 addr0", mv_addr, 32'h1000);
        beat(4'd4, 1'b1);
        chk("R8 remaining", 32'(remaining), 4);
        chk("R4 addr1", mv_addr, 32'h1004);
        chk("R8 no eob yet", 32'(irq_eob), 0);
        beat(4'd4, 1'b1);
        chk("R8 eob pulse", 32'(irq_eob), 1);
        chk("R4 en cleared", 32'(sts_en), 0);
        chk("R4 act cleared", 32'(sts_act), 0);
        chk("R4 no fetch", 32'(mem_req), 0);
        tick();
        chk("R8 eob one cycle", 32'(irq_eob), 0);

        // R10 stop with drain
        do_reset();
        wr(2'd0, 32'h0010_0001);
        xfer_req = 1'b1; fifo_empty = 1'b0;
        wr(2'd0, 32'h0010_0000);
        chk("R10 drain", 32'(fifo_drain), 1);
        chk("R10 en held", 32'(sts_en), 1);
        chk("R10 mv idle", 32'(mv_req), 0);
        tick();
        chk("R10 en still held", 32'(sts_en), 1);
        fifo_empty = 1'b1;
        tick();
        chk("R10 en clear", 32'(sts_en), 0);
        chk("R10 act clear", 32'(sts_act), 0);
        chk("R10 drain off", 32'(fifo_drain), 0);

        // R11 burst lock
        do_reset();
        wr(2'd0, 32'h0010_0081);
        xfer_req = 1'b1;
        beat(4'd4, 1'b0);
        wr(2'd0, 32'h0010_0080);
        chk("R11 no drain mid burst", 32'(fifo_drain), 0);
        xfer_req = 1'b0; #1;
        chk("R11 burst continues", 32'(mv_req), 1);
        beat(4'd4, 1'b1);
        chk("R11 drain after last", 32'(fifo_drain), 1);
        chk("R11 remaining", 32'(remaining), 8);
        tick();
        chk("R11 stopped", 32'(sts_en), 0);

        // R6 R5 R7 run and link
        do_reset();
        wr(2'd1, 32'h200);
        wr(2'd2, 32'h1000);
        wr(2'd0, 32'h0004_000B);
        xfer_req = 1'b1;
        beat(4'd4, 1'b1);
        chk("R6 fetch starts", 32'(mem_req), 1);
        chk("R6 en cleared", 32'(sts_en), 0);
        chk("R6 act held", 32'(sts_act), 1);
        dw[0] = 32'h300; dw[1] = 32'h2000; dw[2] = 32'h0004_0049; dw[3] = 32'hDEAD;
        for (int k = 0; k < 4; k++) begin
            chk("R5 word order", mem_addr, 32'h200 + 32'(k) * 4);
            serve(dw[k]);
        end
        chk("R7 desc irq", 32'(irq_desc), 1);
        chk("R6 running again", 32'(sts_en), 1);
        chk("R7 buf loaded", mv_addr, 32'h2000);
        chk("R7 len loaded", 32'(remaining), 4);
        chk("R6 fetch done", 32'(mem_req), 0);
        tick();
        chk("R7 irq one cycle", 32'(irq_desc), 0);

        // R5 R12 skip then software resume
        do_reset();
        wr(2'd1, 32'h400);
        wr(2'd0, 32'h0000_0002);
        tick();
        chk("R5 waits for request", 32'(sts_act), 0);
        xfer_req = 1'b1;
        tick();
        chk("R5 fetch", 32'(mem_req), 1);
        chk("R5 no data", 32'(mv_req), 0);
        dw[0] = 32'h500; dw[1] = 32'h3000; dw[2] = 32'h0008_0008; dw[3] = 32'h0;
        for (int k = 0; k < 4; k++) begin
            chk("R5 skip order", mem_addr, 32'h400 + 32'(k) * 4);
            serve(dw[k]);
        end
        chk("R12 left disabled", 32'(sts_en), 0);
        chk("R12 frozen", 32'(sts_act), 0);
        chk("R7 irq disabled", 32'(irq_desc), 0);
        chk("R7 len", 32'(remaining), 8);
        tick();
        chk("R5 no refetch", 32'(mem_req), 0);
        wr(2'd0, 32'h0008_0009);
        chk("R12 resume", 32'(mv_req), 1);
        chk("R12 addr", mv_addr, 32'h3000);

        // R8 count hits zero without end-of-buffer enable
        do_reset();
        wr(2'd0, 32'h0004_0021);
        xfer_req = 1'b1;
        beat(4'd4, 1'b1);
        chk("R8 zero", 32'(remaining), 0);
        chk("R8 irq", 32'(irq_eob), 1);
        chk("R8 stays enabled", 32'(sts_en), 1);
        chk("R8 mover idle", 32'(mv_req), 0);

        // R9 end-of-transfer and end-of-buffer in the same cycle
        do_reset();
        wr(2'd0, 32'h0004_003D);
        xfer_req = 1'b1;
        ep_end = 1'b1;
        beat(4'd4, 1'b1);
        chk("R9 eot", 32'(irq_eot), 1);
        chk("R9 eob", 32'(irq_eob), 1);
        chk("R9 ended", {30'b0, sts_en, sts_act}, 0);
        tick();
        chk("R9 pulses gone", {30'b0, irq_eot, irq_eob}, 0);
        wr(2'd0, 32'h0010_003D);
        ep_end = 1'b1;
        @(negedge clk);
        ep_end = 1'b0; #1;
        chk("R9 eot alone", 32'(irq_eot), 1);
        chk("R9 no eob", 32'(irq_eob), 0);
        chk("R9 ended early", 32'(sts_en), 0);
        chk("R9 count kept", 32'(remaining), 16);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule